// File: doc/BRIEF.md
# Open-Row-First Request Selector

This block decides which pending DRAM request a memory controller should issue next. It keeps a short queue of requests in arrival order, oldest at index 0. For every bank it also holds the currently open row and the time at which the bank becomes free. Each cycle it works out a winner from the registered queue and bank state, and it registers that winner as an index with a valid flag. The selected entry's rank, bank and row are presented beside the index.

Two policies are available. In plain first-come-first-served mode the head of the queue always wins. In open-row-first mode the oldest request that hits its bank's open row wins. When no request hits, the winner is the oldest request whose bank is already free or whose bank is flagged in a mask of soonest-free banks. A companion unit supplies that mask, and the selector asks for it only when no row hit exists. If no entry qualifies under either rule, the head wins so that the queue always makes progress.

Requests arrive through a one-cycle enqueue strobe gated by a ready flag. A dequeue strobe removes the entry that is currently selected. A bank update strobe writes one bank's open-row state and free time.

Top module: `frfcfs_sel`

## Requirements
- R1: With `mode` = 0 (first-come-first-served), a valid selection is always index 0, the oldest entry, whatever the row and bank state is.
- R2: With `mode` = 1, the oldest entry whose bank has its open flag set and whose open row equals the entry's row is selected, ahead of all other entries.
- R3: With `mode` = 1 and no row hit, the oldest entry whose bank free time is less than or equal to `now_time` is selected.
- R4: With `mode` = 1 and no row hit, an entry whose bank's bit is set in `emask` is as eligible as a free bank, and among all eligible entries the oldest is selected.
- R5: An entry's flat bank number, used for bank state lookup, for `emask` bit position and for `upd_bank_id`, is rank × BANKS_PER_RANK + bank. With 8 banks per rank, rank 1 bank 0 is bank 8 and uses `emask` bit 8.
- R6: `emask_req` is high exactly when `mode` = 1, the queue is not empty and no entry is a row hit.
- R7: With `mode` = 1, if no entry is a row hit and none is eligible under R3 or R4, index 0 is selected.
- R8: After reset, and whenever the queue is empty, `sel_valid` is 0, `sel_idx` is 0 and `emask_req` is 0. After reset `enq_ready` is 1.
- R9: A cycle with an accepted enqueue, an accepted dequeue or a bank update makes `sel_valid` 0 after that clock edge. The selection for the new state appears, valid, one edge later.
- R10: A dequeue is accepted only while `sel_valid` is 1. It removes the entry at `sel_idx`, and the younger entries move up one place with their order kept. A dequeue while `sel_valid` is 0 has no effect.
- R11: `enq_ready` is 0 while the queue holds DEPTH entries, and an enqueue strobe is then ignored. An enqueue and a dequeue in the same cycle both take effect, and the new entry lands behind all remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 0 = first-come-first-served, 1 = open-row-first |
| enq_valid | input | 1 | Enqueue strobe |
| enq_rank | input | RANK_W | Rank of the new request |
| enq_bank | input | BANK_W | Bank within rank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| enq_ready | output | 1 | Queue has room |
| deq_valid | input | 1 | Remove the selected entry |
| upd_valid | input | 1 | Bank state write strobe |
| upd_bank_id | input | ID_W | Flat bank number to write |
| upd_row_open | input | 1 | 1 = a row is open in that bank |
| upd_row | input | ROW_W | Open row number |
| upd_free_at | input | TIME_W | Time at which the bank becomes free |
| now_time | input | TIME_W | Current time |
| emask_req | output | 1 | Request for the soonest-free bank mask |
| emask | input | NBANK | Soonest-free bank mask, one bit per flat bank |
| sel_valid | output | 1 | Selection is valid |
| sel_idx | output | IDX_W | Queue index of the selected entry |
| sel_rank | output | RANK_W | Rank of the selected entry |
| sel_bank | output | BANK_W | Bank of the selected entry |
| sel_row | output | ROW_W | Row of the selected entry |

## Verification
An enqueue and a dequeue can land in the same cycle. The shift that closes the gap left by the removed entry and the write of the new entry into the tail slot then act on the same registers. The bench provokes this with a part-drained queue of known rows, raising both strobes on one edge. It then drains the queue in first-come-first-served mode and requires the rows to appear in the order the queue model predicts, with the new row last. A similar overlap between a dequeue and a stale selection is provoked by raising the dequeue strobe on the cycle after a bank update, and the bench expects the head row to be unchanged.

// File: rtl/frfcfs_sel_pkg.sv
// Package: shared scheduling mode encoding for the request selector.
// Assumes the mode pin carries this encoding directly.
package frfcfs_sel_pkg;

    typedef enum logic {
        SCHED_FCFS   = 1'b0,
        SCHED_FRFCFS = 1'b1
    } sched_mode_e;

endpackage

// File: rtl/frfcfs_req_queue.sv
// Ordered request queue, oldest entry at index 0.
// Appends at the tail, removes any one index and closes the gap.
// Assumes deq_fire only when deq_idx < count (guaranteed by the top).
module frfcfs_req_queue #(
    parameter int DEPTH          = 16,
    parameter int BANKS_PER_RANK = 8,
    parameter int RANK_W         = 1,
    parameter int BANK_W         = 3,
    parameter int ROW_W          = 14,
    parameter int ID_W           = 4,
    parameter int IDX_W          = 4,
    parameter int CNT_W          = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [RANK_W-1:0] enq_rank,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic              deq_fire,
    input  logic [IDX_W-1:0]  deq_idx,
    output logic              enq_ready,
    output logic              enq_fire,
    output logic [CNT_W-1:0]  count,
    output logic [RANK_W-1:0] q_rank [DEPTH],
    output logic [BANK_W-1:0] q_bank [DEPTH],
    output logic [ROW_W-1:0]  q_row  [DEPTH],
    output logic [ID_W-1:0]   q_id   [DEPTH]
);

    logic [RANK_W-1:0] n_rank [DEPTH];
    logic [BANK_W-1:0] n_bank [DEPTH];
    logic [ROW_W-1:0]  n_row  [DEPTH];
    logic [ID_W-1:0]   n_id   [DEPTH];
    logic [CNT_W-1:0]  cnt_after;
    logic [ID_W-1:0]   enq_id;

    // Room flag and accepted enqueue.
    assign enq_ready = (count < CNT_W'(DEPTH));
    assign enq_fire  = enq_valid && enq_ready;

    // Flat bank number: rank times banks-per-rank plus bank.
    assign enq_id = ID_W'(enq_rank) * ID_W'(BANKS_PER_RANK) + ID_W'(enq_bank);

    // Count after the removal, used as the tail slot for a new entry.
    assign cnt_after = count - (deq_fire ? CNT_W'(1) : CNT_W'(0));

    // Next queue contents: close the gap, then append.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            n_rank[i] = q_rank[i];
            n_bank[i] = q_bank[i];
            n_row[i]  = q_row[i];
            n_id[i]   = q_id[i];
        end
        if (deq_fire) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(deq_idx)) begin
                    n_rank[i] = q_rank[i+1];
                    n_bank[i] = q_bank[i+1];
                    n_row[i]  = q_row[i+1];
                    n_id[i]   = q_id[i+1];
                end
            end
        end
        if (enq_fire) begin
            n_rank[cnt_after[IDX_W-1:0]] = enq_rank;
            n_bank[cnt_after[IDX_W-1:0]] = enq_bank;
            n_row[cnt_after[IDX_W-1:0]]  = enq_row;
            n_id[cnt_after[IDX_W-1:0]]   = enq_id;
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                q_rank[i] <= '0;
                q_bank[i] <= '0;
                q_row[i]  <= '0;
                q_id[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                q_rank[i] <= n_rank[i];
                q_bank[i] <= n_bank[i];
                q_row[i]  <= n_row[i];
                q_id[i]   <= n_id[i];
            end
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= cnt_after + (enq_fire ? CNT_W'(1) : CNT_W'(0));
        end
    end

endmodule

// File: rtl/frfcfs_bank_table.sv
// Per-bank state: open flag, open row and free time.
// One bank is written per cycle through the update strobe.
// Assumes ids at or above NBANK are simply not matched.
module frfcfs_bank_table #(
    parameter int NBANK  = 16,
    parameter int ID_W   = 4,
    parameter int ROW_W  = 14,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [ID_W-1:0]   upd_bank_id,
    input  logic              upd_row_open,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [TIME_W-1:0] upd_free_at,
    output logic [NBANK-1:0]  open_vld,
    output logic [ROW_W-1:0]  open_row [NBANK],
    output logic [TIME_W-1:0] free_at  [NBANK]
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit_me;
        // Decode of the update target.
        assign hit_me = upd_valid && (upd_bank_id == ID_W'(b));

        // State register for one bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_vld[b] <= 1'b0;
                open_row[b] <= '0;
                free_at[b]  <= '0;
            end else if (hit_me) begin
                open_vld[b] <= upd_row_open;
                open_row[b] <= upd_row;
                free_at[b]  <= upd_free_at;
            end
        end
    end

endmodule

// File: rtl/frfcfs_picker.sv
// Combinational winner search over the registered queue.
// Row hits first, then free or soonest-free banks, then the head.
// Assumes entries at or above count are stale and must be masked.
module frfcfs_picker #(
    parameter int DEPTH  = 16,
    parameter int NBANK  = 16,
    parameter int ID_W   = 4,
    parameter int ROW_W  = 14,
    parameter int TIME_W = 32,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5
) (
    input  logic              mode_fr,
    input  logic [CNT_W-1:0]  count,
    input  logic [ID_W-1:0]   q_id  [DEPTH],
    input  logic [ROW_W-1:0]  q_row [DEPTH],
    input  logic [NBANK-1:0]  open_vld,
    input  logic [ROW_W-1:0]  open_row [NBANK],
    input  logic [TIME_W-1:0] free_at  [NBANK],
    input  logic [TIME_W-1:0] now_time,
    input  logic [NBANK-1:0]  emask,
    output logic [IDX_W-1:0]  pick_idx,
    output logic              emask_req
);

    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] rdy_vec;
    logic [IDX_W-1:0] first_hit;
    logic [IDX_W-1:0] first_rdy;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic live;
        logic in_rng;
        // Entry is occupied.
        assign live = (CNT_W'(e) < count);
        if (NBANK == (1 << ID_W)) begin : g_full
            assign in_rng = 1'b1;
        end else begin : g_part
            assign in_rng = (q_id[e] < ID_W'(NBANK));
        end
        // Row hit: bank open on the same row.
        assign hit_vec[e] = live && in_rng && open_vld[q_id[e]]
                            && (open_row[q_id[e]] == q_row[e]);
        // Ready: bank already free or in the soonest-free mask.
        assign rdy_vec[e] = live && in_rng
                            && ((free_at[q_id[e]] <= now_time) || emask[q_id[e]]);
    end

    // Lowest-index (oldest) set bit of each candidate vector.
    always_comb begin
        first_hit = '0;
        first_rdy = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_hit = IDX_W'(i);
            if (rdy_vec[i]) first_rdy = IDX_W'(i);
        end
    end

    // Policy ladder.
    always_comb begin
        if (!mode_fr)          pick_idx = '0;
        else if (|hit_vec)     pick_idx = first_hit;
        else if (|rdy_vec)     pick_idx = first_rdy;
        else                   pick_idx = '0;
    end

    // The mask is only wanted when no hit exists.
    assign emask_req = mode_fr && (count != '0) && !(|hit_vec);

endmodule

// File: rtl/frfcfs_sel.sv
// Top of the request selector: queue, bank table, picker and the
// registered result. Any change to queue or bank state drops the
// valid flag for one cycle so a stale index is never dequeued.
module frfcfs_sel #(
    parameter int DEPTH          = 16,
    parameter int RANKS          = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int ROW_W          = 14,
    parameter int TIME_W         = 32,
    localparam int NBANK  = RANKS * BANKS_PER_RANK,
    localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BANK_W = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
    localparam int ID_W   = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              enq_valid,
    input  logic [RANK_W-1:0] enq_rank,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    output logic              enq_ready,
    input  logic              deq_valid,
    input  logic              upd_valid,
    input  logic [ID_W-1:0]   upd_bank_id,
    input  logic              upd_row_open,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [TIME_W-1:0] upd_free_at,
    input  logic [TIME_W-1:0] now_time,
    output logic              emask_req,
    input  logic [NBANK-1:0]  emask,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [RANK_W-1:0] sel_rank,
    output logic [BANK_W-1:0] sel_bank,
    output logic [ROW_W-1:0]  sel_row
);

    import frfcfs_sel_pkg::*;

    sched_mode_e       mode_e;
    logic              enq_fire;
    logic              deq_fire;
    logic              changed;
    logic [CNT_W-1:0]  q_count;
    logic [RANK_W-1:0] q_rank [DEPTH];
    logic [BANK_W-1:0] q_bank [DEPTH];
    logic [ROW_W-1:0]  q_row  [DEPTH];
    logic [ID_W-1:0]   q_id   [DEPTH];
    logic [NBANK-1:0]  open_vld;
    logic [ROW_W-1:0]  open_row [NBANK];
    logic [TIME_W-1:0] free_at  [NBANK];
    logic [IDX_W-1:0]  pick_idx;
    logic              sel_valid_q;
    logic [IDX_W-1:0]  sel_idx_q;

    // Mode decode.
    assign mode_e   = sched_mode_e'(mode);
    // Dequeue only against a fresh, valid selection.
    assign deq_fire = deq_valid && sel_valid_q;
    // Any state change invalidates the registered winner.
    assign changed  = enq_fire || deq_fire || upd_valid;

    frfcfs_req_queue #(
        .DEPTH(DEPTH), .BANKS_PER_RANK(BANKS_PER_RANK), .RANK_W(RANK_W),
        .BANK_W(BANK_W), .ROW_W(ROW_W), .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_rank(enq_rank), .enq_bank(enq_bank),
        .enq_row(enq_row), .deq_fire(deq_fire), .deq_idx(sel_idx_q),
        .enq_ready(enq_ready), .enq_fire(enq_fire), .count(q_count),
        .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row), .q_id(q_id)
    );

    frfcfs_bank_table #(
        .NBANK(NBANK), .ID_W(ID_W), .ROW_W(ROW_W), .TIME_W(TIME_W)
    ) u_banks (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_bank_id(upd_bank_id),
        .upd_row_open(upd_row_open), .upd_row(upd_row), .upd_free_at(upd_free_at),
        .open_vld(open_vld), .open_row(open_row), .free_at(free_at)
    );

    frfcfs_picker #(
        .DEPTH(DEPTH), .NBANK(NBANK), .ID_W(ID_W), .ROW_W(ROW_W),
        .TIME_W(TIME_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_pick (
        .mode_fr(mode_e == SCHED_FRFCFS), .count(q_count),
        .q_id(q_id), .q_row(q_row), .open_vld(open_vld),
        .open_row(open_row), .free_at(free_at), .now_time(now_time),
        .emask(emask), .pick_idx(pick_idx), .emask_req(emask_req)
    );

    // Registered selection result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid_q <= 1'b0;
            sel_idx_q   <= '0;
        end else begin
            sel_valid_q <= (q_count != '0) && !changed;
            sel_idx_q   <= pick_idx;
        end
    end

    // Result outputs and the selected entry's fields.
    assign sel_valid = sel_valid_q;
    assign sel_idx   = sel_idx_q;
    assign sel_rank  = q_rank[sel_idx_q];
    assign sel_bank  = q_bank[sel_idx_q];
    assign sel_row   = q_row[sel_idx_q];

endmodule

// File: rtl/frfcfs_sel_chk.sv
// Checker bound to the selector top; observes occupancy, strobes and result.
module frfcfs_sel_chk #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode,
    input logic [CNT_W-1:0] q_count,
    input logic             enq_fire,
    input logic             deq_fire,
    input logic             upd_valid,
    input logic             enq_ready,
    input logic             sel_valid,
    input logic [IDX_W-1:0] sel_idx,
    input logic             emask_req
);

    p_fcfs_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !$past(mode)) |-> (sel_idx == '0));

    p_req_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        emask_req |-> (mode && q_count != '0));

    p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0) |=> (!sel_valid && sel_idx == '0));

    p_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_fire || deq_fire || upd_valid) |=> !sel_valid);

    p_idx_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (CNT_W'(sel_idx) < q_count));

    p_deq_shrink_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_fire && !enq_fire) |=> (q_count == $past(q_count) - CNT_W'(1)));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(DEPTH)) |-> !enq_ready);

endmodule

bind frfcfs_sel frfcfs_sel_chk #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .q_count(q_count),
    .enq_fire(enq_fire), .deq_fire(deq_fire), .upd_valid(upd_valid),
    .enq_ready(enq_ready), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .emask_req(emask_req)
);

// File: tb/frfcfs_sel_tb.sv
module frfcfs_sel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        enq_valid = 1'b0;
    logic [0:0]  enq_rank = '0;
    logic [2:0]  enq_bank = '0;
    logic [13:0] enq_row = '0;
    logic        enq_ready;
    logic        deq_valid = 1'b0;
    logic        upd_valid = 1'b0;
    logic [3:0]  upd_bank_id = '0;
    logic        upd_row_open = 1'b0;
    logic [13:0] upd_row = '0;
    logic [31:0] upd_free_at = '0;
    logic [31:0] now_time = '0;
    logic        emask_req;
    logic [15:0] emask = '0;
    logic        sel_valid;
    logic [3:0]  sel_idx;
    logic [0:0]  sel_rank;
    logic [2:0]  sel_bank;
    logic [13:0] sel_row;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frfcfs_sel u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .enq_valid(enq_valid), .enq_rank(enq_rank), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_ready(enq_ready), .deq_valid(deq_valid),
        .upd_valid(upd_valid), .upd_bank_id(upd_bank_id),
        .upd_row_open(upd_row_open), .upd_row(upd_row), .upd_free_at(upd_free_at),
        .now_time(now_time), .emask_req(emask_req), .emask(emask),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_rank(sel_rank),
        .sel_bank(sel_bank), .sel_row(sel_row)
    );

    // Vector: mode, now, mask, bank 13 hits, expected index, expected request.
    typedef struct packed {
        logic        md;
        logic [31:0] now;
        logic [15:0] msk;
        logic        hit13;
        logic [3:0]  exp_idx;
        logic        exp_req;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b0, 32'd0,   16'h0000, 1'b1, 4'd0, 1'b0},  // R1 head despite hit
        '{1'b1, 32'd0,   16'h0000, 1'b1, 4'd3, 1'b0},  // R2 hit wins
        '{1'b1, 32'd0,   16'h0000, 1'b0, 4'd0, 1'b1},  // R7 nothing eligible
        '{1'b1, 32'd35,  16'h0000, 1'b0, 4'd2, 1'b1},  // R3 bank 8 free
        '{1'b1, 32'd45,  16'h0000, 1'b0, 4'd1, 1'b1},  // R3 oldest free
        '{1'b1, 32'd50,  16'h0000, 1'b0, 4'd0, 1'b1},  // R3 all but 13 free
        '{1'b1, 32'd0,   16'h0100, 1'b0, 4'd2, 1'b1},  // R5 bit 8 = rank1 bank0
        '{1'b1, 32'd0,   16'h2000, 1'b0, 4'd3, 1'b1},  // R4 mask only
        '{1'b1, 32'd35,  16'h2000, 1'b0, 4'd2, 1'b1},  // R4 age decides
        '{1'b1, 32'd0,   16'h2008, 1'b0, 4'd1, 1'b1},  // R4 two mask bits
        '{1'b0, 32'd0,   16'h0000, 1'b0, 4'd0, 1'b0},  // R1 / R6 no request
        '{1'b1, 32'd100, 16'h0000, 1'b1, 4'd3, 1'b0},  // R2 hit beats free
        '{1'b1, 32'd0,   16'h0002, 1'b0, 4'd0, 1'b1}   // R7 mask bit of no entry
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic enq(input logic r, input logic [2:0] b, input logic [13:0] row);
        enq_valid = 1'b1; enq_rank = r; enq_bank = b; enq_row = row;
        step();
        enq_valid = 1'b0;
    endtask

    task automatic bank_upd(input logic [3:0] id, input logic op, input logic [13:0] row,
                            input logic [31:0] fa);
        upd_valid = 1'b1; upd_bank_id = id; upd_row_open = op;
        upd_row = row; upd_free_at = fa;
        step();
        upd_valid = 1'b0;
    endtask

    task automatic deq_one();
        deq_valid = 1'b1;
        step();
        deq_valid = 1'b0;
    endtask

    task automatic drain_expect(input string tag, input logic [13:0] row);
        step(); step();
        check({tag, " valid"}, 32'(sel_valid), 32'd1);
        check({tag, " row"}, 32'(sel_row), 32'(row));
        deq_one();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R8 reset state
        check("R8 reset sel_valid", 32'(sel_valid), 32'd0);
        check("R8 reset sel_idx", 32'(sel_idx), 32'd0);
        check("R8 reset enq_ready", 32'(enq_ready), 32'd1);
        check("R8 reset emask_req", 32'(emask_req), 32'd0);
        rst_n = 1'b1;
        step();

        // Bank state and a four-entry queue (rows 100..400).
        bank_upd(4'd0, 1'b1, 14'd7, 32'd50);
        bank_upd(4'd3, 1'b1, 14'd9, 32'd40);
        bank_upd(4'd8, 1'b0, 14'd0, 32'd30);
        enq(1'b0, 3'd0, 14'd100);
        enq(1'b0, 3'd3, 14'd200);
        enq(1'b1, 3'd0, 14'd300);
        enq(1'b1, 3'd5, 14'd400);
        check("R9 valid drops after enqueue", 32'(sel_valid), 32'd0);
        step();
        check("R9 valid returns", 32'(sel_valid), 32'd1);

        // Vector walk (R1 R2 R3 R4 R5 R6 R7).
        for (int i = 0; i < 13; i++) begin
            mode = VECS[i].md;
            now_time = VECS[i].now;
            emask = VECS[i].msk;
            bank_upd(4'd13, 1'b1, VECS[i].hit13 ? 14'd400 : 14'd401, 32'd90);
            check($sformatf("R9 vec %0d settle", i), 32'(sel_valid), 32'd0);
            step(); step();
            check($sformatf("vec %0d valid", i), 32'(sel_valid), 32'd1);
            check($sformatf("vec %0d idx R2 R3 R4 R5 R7", i), 32'(sel_idx), 32'(VECS[i].exp_idx));
            check($sformatf("vec %0d R6 emask_req", i), 32'(emask_req), 32'(VECS[i].exp_req));
            check($sformatf("vec %0d row", i), 32'(sel_row), 32'(VECS[i].exp_idx) * 100 + 100);
        end

        // R10: dequeue while valid is low has no effect.
        mode = 1'b0; now_time = '0; emask = '0;
        bank_upd(4'd13, 1'b1, 14'd400, 32'd90);
        deq_one();
        step(); step();
        check("R10 ignored deq head row", 32'(sel_row), 32'd100);

        // R10: dequeue of a middle entry (the row hit).
        mode = 1'b1;
        step(); step();
        check("R2 hit before deq", 32'(sel_idx), 32'd3);
        check("R5 sel_rank", 32'(sel_rank), 32'd1);
        check("R5 sel_bank", 32'(sel_bank), 32'd5);
        deq_one();
        mode = 1'b0;
        drain_expect("R10 order 0", 14'd100);
        drain_expect("R10 order 1", 14'd200);
        drain_expect("R10 order 2", 14'd300);
        step(); step();
        mode = 1'b1;
        step();
        check("R8 empty sel_valid", 32'(sel_valid), 32'd0);
        check("R8 empty sel_idx", 32'(sel_idx), 32'd0);
        check("R8 empty emask_req", 32'(emask_req), 32'd0);

        // R2: two hits, the older wins; closing its bank moves the pick.
        enq(1'b0, 3'd0, 14'd5);
        enq(1'b0, 3'd3, 14'd9);
        enq(1'b1, 3'd5, 14'd400);
        step();
        check("R2 oldest hit idx", 32'(sel_idx), 32'd1);
        check("R2 oldest hit row", 32'(sel_row), 32'd9);
        bank_upd(4'd3, 1'b0, 14'd9, 32'd40);
        step();
        check("R2 closed bank not a hit", 32'(sel_idx), 32'd2);
        mode = 1'b0;
        drain_expect("R1 drain a", 14'd5);
        drain_expect("R1 drain b", 14'd9);
        drain_expect("R1 drain c", 14'd400);

        // R11: fill, overflow attempt, then enqueue and dequeue together.
        for (int i = 0; i < 16; i++) enq(1'b0, 3'd1, 14'(1000 + i));
        check("R11 full enq_ready", 32'(enq_ready), 32'd0);
        enq(1'b0, 3'd1, 14'd999);
        drain_expect("R11 full head", 14'd1000);
        drain_expect("R11 second", 14'd1001);
        step(); step();
        check("R11 ready after drain", 32'(enq_ready), 32'd1);
        check("R11 pre-overlap head", 32'(sel_row), 32'd1002);
        enq_valid = 1'b1; enq_rank = 1'b0; enq_bank = 3'd2; enq_row = 14'd2000;
        deq_valid = 1'b1;
        step();
        enq_valid = 1'b0; deq_valid = 1'b0;
        for (int i = 3; i < 16; i++) drain_expect($sformatf("R11 drain %0d", i), 14'(1000 + i));
        drain_expect("R11 new entry last", 14'd2000);
        step(); step();
        check("R11 R8 empty at end", 32'(sel_valid), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule